// File: doc/BRIEF.md
# DMA Channel Parameter and Terminal-Count Block

This block holds the transfer parameters of a four-channel DMA engine. Each channel has a 16-bit current address and a 16-bit count word. The low 14 bits of the count word give the cycles left before the last one. The top 2 bits give the transfer kind. A CPU programs these registers, and reads them back, through a byte-wide slave register port. A 16-bit value takes two byte accesses in a row, low byte first. A shared byte-select flip-flop decides which half each access touches.

The bus sequencer that runs the transfers sends one `cyc_done` pulse per completed DMA cycle for each channel. On that pulse the block steps the channel's address and count. In the same cycle it reports two strobes: terminal count, when the pulse belongs to the channel's final cycle, and mark, on every 128th cycle counted back from the end of the block. Terminal-count events are kept as sticky flags in a status byte, and reading that byte clears them. When autoload is turned on, a terminal count on channel 2 reloads channel 2 from channel 3's registers. A status flag reports that reload on the following cycle.

Every pin is a plain control or status signal, sampled or driven on each clock. There is no valid/ready handshake, and the block never applies back-pressure. A register access is complete in the cycle its strobe is high, and a `cyc_done` pulse is always accepted.

Top module: `dma_chan_regs`

## Requirements
- R1: Each of the 4 channels has a 16-bit address register and a 16-bit count register. A channel register sits at `reg_addr` bit 3 = 0, with the channel in bits 2:1 and bit 0 selecting address (0) or count (1). A write stores `reg_wdata` into the low byte when the byte-select flip-flop is 0 and into the high byte when it is 1.
- R2: The byte-select flip-flop toggles on every read or write of a channel register. A write to the mode register (`reg_addr` bit 3 = 1) clears it. A channel register read returns the byte chosen by the flip-flop on `reg_rdata`, in the same cycle.
- R3: Count register bits 15:14 give the transfer kind, driven on `op_kind[2c+1:2c]` for channel c: 00 verify, 01 write, 10 read, 11 illegal. Bits 13:0 hold N-1 for a block of N cycles.
- R4: A `cyc_done[c]` pulse adds one to channel c's address and subtracts one from count bits 13:0 (0 wraps to 3FFF), leaving bits 15:14 unchanged. A CPU write to a register in the same cycle replaces that register's step.
- R5: `tc[c]` is high exactly in the cycle of a `cyc_done[c]` pulse that finds count bits 13:0 equal to 0, which is the Nth pulse after loading N-1.
- R6: A read with `reg_addr` bit 3 = 1 returns the status byte. Bits 3:0 are the per-channel terminal-count flags, bit 4 is the update flag and bits 7:5 are 0. A flag sets on its channel's `tc` and stays set until a status read, which clears all flags at that clock edge. A flag set in the same cycle as the read survives the clear.
- R7: `mark[c]` is high in the cycle of a `cyc_done[c]` pulse that finds count bits 6:0 equal to 127, so that a multiple of 128 cycles remains, counting the current one.
- R8: Bit 0 of a mode write enables autoload. With autoload on, a terminal count on channel 2 loads channel 3's address and count into channel 2 at that clock edge, in place of the step.
- R9: The status update flag reads 1 in the cycle after an autoload reload and 0 otherwise.
- R10: Reset clears every address and count register, the mode bit, all status flags and the byte-select flip-flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe; takes precedence over a read in the same cycle |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte, combinational from the current state and `reg_addr` |
| cyc_done | input | 4 | One bit per channel: a DMA cycle finished this clock |
| cur_addr | output | 64 | Current address, channel c in bits 16c+15:16c |
| op_kind | output | 8 | Transfer kind, channel c in bits 2c+1:2c |
| tc | output | 4 | Terminal-count strobe per channel |
| mark | output | 4 | 128-cycle mark strobe per channel |

## Verification
`tc`, `mark` and `reg_rdata` are combinational, so they are due in the same cycle as their `cyc_done` pulse or access. The bench samples them a quarter period after driving its inputs. Register contents and status flags change at the next rising edge. The bench advances its behavioural model only after that edge and compares `cur_addr`, `op_kind` and the status byte in the following cycle. The update flag is therefore expected exactly one cycle after the channel 2 terminal count that caused the reload. Same-cycle collisions are driven on purpose, so each tie rule is checked on the cycle it governs: a status read with a new terminal count, and a CPU write with a `cyc_done` pulse.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {
    OP_VERIFY = 2'b00,
    OP_WRITE  = 2'b01,
    OP_READ   = 2'b10,
    OP_BAD    = 2'b11
  } op_kind_t;
endpackage

// File: rtl/dma_chan_slot.sv
module dma_chan_slot #(
  parameter int AW = 16,
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr,
  input  logic          c_wr,
  input  logic          hi_sel,
  input  logic [7:0]    wdata,
  input  logic          step,
  input  logic          reload,
  input  logic [AW-1:0] rl_addr,
  input  logic [AW-1:0] rl_cnt,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] cnt_q
);
  localparam int KW = AW - CW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (a_wr) begin
      if (hi_sel) addr_q[AW-1:8] <= wdata;
      else        addr_q[7:0]    <= wdata;
    end else if (reload) begin
      addr_q <= rl_addr;
    end else if (step) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (c_wr) begin
      if (hi_sel) cnt_q[AW-1:8] <= wdata;
      else        cnt_q[7:0]    <= wdata;
    end else if (reload) begin
      cnt_q <= rl_cnt;
    end else if (step) begin
      cnt_q <= {cnt_q[AW-1 -: KW], cnt_q[CW-1:0] - 1'b1};
    end
  end
endmodule

// File: rtl/dma_status.sv
module dma_status #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tc_hit,
  input  logic           clr,
  input  logic           al_fire,
  output logic [NCH-1:0] tc_flags,
  output logic           upd_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_flags <= '0;
      upd_flag <= 1'b0;
    end else begin
      tc_flags <= (clr ? '0 : tc_flags) | tc_hit;
      upd_flag <= al_fire;
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_cnt_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int AW    = 16,
  parameter int CW    = 14,
  parameter int MK_W  = 7,
  parameter int AL_DST = 2,
  parameter int AL_SRC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [NCH-1:0]    cyc_done,
  output logic [NCH*AW-1:0] cur_addr,
  output logic [NCH*2-1:0]  op_kind,
  output logic [NCH-1:0]    tc,
  output logic [NCH-1:0]    mark
);
  localparam int SW = $clog2(NCH);

  logic          hi_ff;
  logic          al_mode;
  logic          is_ch;
  logic [SW-1:0] ch_sel;
  logic          ch_acc;
  logic          clr;
  logic          al_fire;
  logic [NCH-1:0] tc_flags;
  logic           upd_flag;
  logic [AW-1:0]  addr_v [NCH];
  logic [AW-1:0]  cnt_v  [NCH];

  assign is_ch  = ~reg_addr[3];
  assign ch_sel = reg_addr[SW:1];
  assign ch_acc = (reg_wr | reg_rd) & is_ch;
  assign clr    = reg_rd & ~reg_wr & ~is_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_ff   <= 1'b0;
      al_mode <= 1'b0;
    end else if (reg_wr & ~is_ch) begin
      hi_ff   <= 1'b0;
      al_mode <= reg_wdata[0];
    end else if (ch_acc) begin
      hi_ff   <= ~hi_ff;
    end
  end

  assign al_fire = al_mode & tc[AL_DST];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_c;
    logic rl_c;
    assign sel_c = reg_wr & is_ch & (ch_sel == SW'(c));
    if (c == AL_DST) begin : g_al
      assign rl_c = al_fire;
    end else begin : g_nal
      assign rl_c = 1'b0;
    end

    dma_chan_slot #(.AW(AW), .CW(CW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_wr    (sel_c & ~reg_addr[0]),
      .c_wr    (sel_c &  reg_addr[0]),
      .hi_sel  (hi_ff),
      .wdata   (reg_wdata),
      .step    (cyc_done[c]),
      .reload  (rl_c),
      .rl_addr (addr_v[AL_SRC]),
      .rl_cnt  (cnt_v[AL_SRC]),
      .addr_q  (addr_v[c]),
      .cnt_q   (cnt_v[c])
    );

    assign cur_addr[c*AW +: AW] = addr_v[c];
    assign op_kind[c*2 +: 2]    = cnt_v[c][AW-1 -: 2];
    assign tc[c]   = cyc_done[c] & (cnt_v[c][CW-1:0] == '0);
    assign mark[c] = cyc_done[c] & (&cnt_v[c][MK_W-1:0]);
  end

  dma_status #(.NCH(NCH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .tc_hit   (tc),
    .clr      (clr),
    .al_fire  (al_fire),
    .tc_flags (tc_flags),
    .upd_flag (upd_flag)
  );

  always_comb begin
    logic [AW-1:0] word;
    word = reg_addr[0] ? cnt_v[ch_sel] : addr_v[ch_sel];
    if (is_ch) reg_rdata = hi_ff ? word[AW-1:8] : word[7:0];
    else       reg_rdata = 8'({upd_flag, tc_flags});
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [NCH-1:0]    cyc_done,
  input logic [NCH*AW-1:0] cur_addr,
  input logic [NCH-1:0]    tc,
  input logic [NCH-1:0]    mark,
  input logic [NCH-1:0]    tc_flags,
  input logic              upd_flag,
  input logic              al_fire
);
  // R5: the strobe only accompanies a completed cycle
  a_r5_tc_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (tc & ~cyc_done) == '0);

  // R6: a terminal count is always recorded in the status flags
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc) |=> ((tc_flags & $past(tc)) == $past(tc)));

  // R4: channel 0 address steps by one when no CPU write interferes
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done[0] && !reg_wr) |=> (cur_addr[AW-1:0] == $past(cur_addr[AW-1:0]) + 1'b1));

  // R7: mark and terminal count never coincide on a channel
  a_r7_mark_not_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (mark & tc) == '0);

  // R9: update flag follows an autoload reload by one cycle
  a_r9_upd_follows: assert property (@(posedge clk) disable iff (!rst_n)
    al_fire |=> upd_flag);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH), .AW(AW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .cyc_done (cyc_done),
  .cur_addr (cur_addr),
  .tc       (tc),
  .mark     (mark),
  .tc_flags (tc_flags),
  .upd_flag (upd_flag),
  .al_fire  (al_fire)
);

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [3:0]  cyc_done = '0;
  logic [63:0] cur_addr;
  logic [7:0]  op_kind;
  logic [3:0]  tc, mark;

  int vecs = 0, errs = 0;
  bit finished = 0;

  int m_addr[4], m_cnt[4];
  int m_ff, m_al, m_tcf, m_upd;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_regs i_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cyc_done(cyc_done), .cur_addr(cur_addr), .op_kind(op_kind),
    .tc(tc), .mark(mark)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit wr, bit rd, int a, int d, int done);
    logic [63:0] ea;
    logic [7:0] eo;
    int et, em, er, w, sa, sc;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = 4'(a); reg_wdata = 8'(d); cyc_done = 4'(done);
    #(CLK_P/4);
    et = 0; em = 0;
    for (int c = 0; c < 4; c++) begin
      ea[c*16 +: 16] = 16'(m_addr[c]);
      eo[c*2 +: 2]   = 2'(m_cnt[c] >> 14);
      if (done[c] && (m_cnt[c] & 16'h3FFF) == 0) et |= (1 << c);
      if (done[c] && (m_cnt[c] & 127) == 127) em |= (1 << c);
    end
    if (a[3]) er = (m_upd << 4) | m_tcf;
    else begin
      w  = a[0] ? m_cnt[(a >> 1) & 3] : m_addr[(a >> 1) & 3];
      er = m_ff ? (w >> 8) & 255 : w & 255;
    end
    chk("R1/R4/R8", "cur_addr", cur_addr, ea);
    chk("R3", "op_kind", op_kind, eo);
    chk("R5", "tc", tc, et);
    chk("R7", "mark", mark, em);
    chk("R2/R6/R9", "reg_rdata", reg_rdata, er);
    @(posedge clk);
    sa = m_addr[3]; sc = m_cnt[3];
    for (int c = 0; c < 4; c++) begin
      bit wa, wc, rl;
      wa = wr && !a[3] && ((a >> 1) & 3) == c && !a[0];
      wc = wr && !a[3] && ((a >> 1) & 3) == c && a[0];
      rl = (c == 2) && m_al && et[2];
      if (wa) m_addr[c] = m_ff ? (m_addr[c] & 255) | (d << 8) : (m_addr[c] & 16'hFF00) | d;
      else if (rl) m_addr[c] = sa;
      else if (done[c]) m_addr[c] = (m_addr[c] + 1) & 16'hFFFF;
      if (wc) m_cnt[c] = m_ff ? (m_cnt[c] & 255) | (d << 8) : (m_cnt[c] & 16'hFF00) | d;
      else if (rl) m_cnt[c] = sc;
      else if (done[c]) m_cnt[c] = (m_cnt[c] & 16'hC000) | (((m_cnt[c] & 16'h3FFF) - 1) & 16'h3FFF);
    end
    m_upd = m_al && et[2];
    m_tcf = ((rd && !wr && a[3]) ? 0 : m_tcf) | et;
    if (wr && a[3]) begin m_ff = 0; m_al = d & 1; end
    else if ((wr || rd) && !a[3]) m_ff ^= 1;
  endtask

  task automatic wr16(int a, int v);
    step(1, 0, a, v & 255, 0);
    step(1, 0, a, (v >> 8) & 255, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int lf;
    for (int c = 0; c < 4; c++) begin m_addr[c] = 0; m_cnt[c] = 0; end
    m_ff = 0; m_al = 0; m_tcf = 0; m_upd = 0;
    #(CLK_P * 3);
    rst_n = 1'b1;
    // R10: reset state seen at the ports
    step(0, 1, 8, 0, 0);
    step(0, 0, 0, 0, 0);
    // R1 R3: channel 0 addr 0x1234, count N=3 with read kind
    wr16(0, 16'h1234);
    wr16(1, 16'h8002);
    // R2: read back both halves
    step(0, 1, 1, 0, 0);
    step(0, 1, 1, 0, 0);
    // R4 R5: three cycles, terminal count on the third
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1);
    // R6: flag readable then cleared
    step(0, 1, 8, 0, 0);
    step(0, 1, 8, 0, 0);
    // R6: read colliding with a new terminal count (ch0 wrapped to 3FFF, use ch1 at 0)
    step(0, 1, 8, 0, 2);
    step(0, 1, 8, 0, 0);
    // R7: channel 1, N=130 with write kind
    wr16(3, 16'h4081);
    for (int i = 0; i < 130; i++) step(0, 0, 0, 0, 2);
    // R4: CPU write in the same cycle as a step on channel 1 address
    step(1, 0, 2, 8'h5A, 2);
    step(1, 0, 2, 8'hA5, 0);
    // R8 R9: autoload from channel 3 into channel 2
    wr16(6, 16'h4000);
    wr16(7, 16'h4001);
    wr16(4, 16'h0100);
    wr16(5, 16'h0000);
    step(1, 0, 8, 1, 0);
    step(0, 0, 0, 0, 4);
    step(0, 1, 8, 0, 0);
    step(0, 1, 8, 0, 4);
    step(0, 0, 0, 0, 4);
    step(0, 1, 8, 0, 0);
    // R2: mode write clears the byte flip-flop mid pair
    step(0, 1, 4, 0, 0);
    step(1, 0, 8, 0, 0);
    step(0, 1, 4, 0, 0);
    // mixed traffic
    lf = 32'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
      step(0, (lf >> 5) & 1, (lf >> 6) & 15, 0, lf & 15);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule